// File: doc/BRIEF.md
# Asynchronous Bus Cycle Master Sequencer

This block is the bus-side sequencer of a processor core. It runs one read or write cycle on a 32-bit, non-multiplexed data bus and lets the addressed device end the cycle with a two-wire, active-low acknowledge. The core raises a one-tick request along with an address, a direction flag, a size code and write data. The block then drives the address strobe, data strobe, data buffer enable and data-bus output enable with read and write timings that differ at half-clock resolution. It inserts wait states until it sees an acknowledge, latches read data and returns a done pulse together with the width of the port that answered.

The block is clocked at twice the bus clock rate. Each `clk_i` tick is one half of a bus clock. Number the ticks of a cycle t = 1, 2, 3, ..., with t = 1 being the tick right after the edge that accepted the request. Odd ticks t >= 3 fall in the bus-clock phase that ends on a falling edge. The acknowledges are sampled at the edge that closes each of those ticks.

Top module: `async_bus_master`

## Requirements
- R1: While `rst_ni` is low, and after reset until a request arrives, `as_no`, `ds_no` and `dben_no` are high, and `data_oe_o` and `done_o` are low.
- R2: In a read, `as_no` and `ds_no` both go low at t = 1 and stay low through tick ts+1, where ts is the tick in which an acknowledge was sampled.
- R3: In a write, `as_no` goes low at t = 1 and `ds_no` goes low at t = 3, one full bus clock later. Both stay low through tick ts+1.
- R4: In a write, `data_oe_o` is high from t = 2 through ts+1, and `data_o` carries all 32 bits of the write data regardless of the size code. `data_oe_o` is never high in a read.
- R5: In a read, `dben_no` is low from t = 3 through ts+1 and negates together with `ds_no`. In a write, it is low from t = 1 through ts+1, matching `as_no`.
- R6: The acknowledges are sampled only at the close of odd ticks t >= 3. A low level at any other tick has no effect. If neither acknowledge is low at a sampling tick, one wait state of two ticks is inserted, with all strobes held.
- R7: The answering port width on `port_o` is decoded from the sampled acknowledges. Both low gives 2'b10 (32-bit). Only `ack1_ni` low gives 2'b01 (16-bit). Only `ack0_ni` low gives 2'b00 (8-bit).
- R8: On a read, `rdata_o` holds the value of `data_i` captured at the edge that closes tick ts+1. It is valid from the done tick onward.
- R9: `done_o` is high for exactly tick ts+2, and all strobes are negated and drivers released in that tick. The block is idle in the following tick.
- R10: `req_i` is ignored while a cycle is in progress. `addr_o`, `size_o` and `bus_wr_o` keep the values latched at acceptance for the whole cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Double-rate clock, one tick per half bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Cycle request from core, taken when idle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | AW | Cycle address |
| size_i | input | 2 | Byte count code: 01=1, 10=2, 11=3, 00=4 |
| wdata_i | input | DW | Write data |
| done_o | output | 1 | One-tick completion pulse |
| rdata_o | output | DW | Latched read data |
| port_o | output | 2 | Answering port width: 00=8, 01=16, 10=32 bits |
| addr_o | output | AW | Bus address |
| size_o | output | 2 | Bus size code |
| bus_wr_o | output | 1 | Bus direction, 1 = write |
| as_no | output | 1 | Address strobe, active low |
| ds_no | output | 1 | Data strobe, active low |
| dben_no | output | 1 | Data buffer enable, active low |
| data_o | output | DW | Bus data out |
| data_oe_o | output | 1 | Bus data output enable |
| data_i | input | DW | Bus data in |
| ack0_ni | input | 1 | Acknowledge 0, active low |
| ack1_ni | input | 1 | Acknowledge 1, active low |

## Verification
Every result is due at a fixed tick count after acceptance. The strobes change at t = 1, 2 and 3 and release at ts+2. The width and done appear at ts+2, and the read data comes from `data_i` at the edge closing ts+1. The bench keeps a behavioural tick counter and the sampled-tick number ts, updates them at each rising edge, and compares every output at the following falling edge. It changes `data_i` every tick, so a capture one tick early or late shows up as a mismatch. Acknowledges are driven per sampling tick, with extra stray low pulses on even ticks.

// File: rtl/amsq_pkg.sv
package amsq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_S1, ST_S2, ST_S3, ST_SW, ST_S4, ST_S5
  } bus_st_e;

  typedef enum logic [1:0] {
    PW_8 = 2'b00, PW_16 = 2'b01, PW_32 = 2'b10
  } port_w_e;

  // active-low acknowledge pair to port width
  function automatic port_w_e port_of(input logic ack0_n, input logic ack1_n);
    case ({ack1_n, ack0_n})
      2'b00:   return PW_32;
      2'b01:   return PW_16;
      default: return PW_8;
    endcase
  endfunction
endpackage

// File: rtl/amsq_fsm.sv
module amsq_fsm
  import amsq_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    req_i,
  input  logic    ack_seen_i,
  output bus_st_e st_o
);
  bus_st_e st_q, st_d;

  always_comb begin
    case (st_q)
      ST_IDLE: st_d = req_i ? ST_S1 : ST_IDLE;
      ST_S1:   st_d = ST_S2;
      ST_S2:   st_d = ST_S3;
      ST_S3:   st_d = ack_seen_i ? ST_S4 : ST_SW;
      ST_SW:   st_d = ST_S3;
      ST_S4:   st_d = ST_S5;
      ST_S5:   st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign st_o = st_q;

  AST_WAIT_FULL_CLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == ST_SW |=> st_q == ST_S3); // R6
  AST_NO_SAMPLE_OFF_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == ST_S4 |-> $past(st_q) == ST_S3); // R6
  AST_DONE_TO_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == ST_S5 |=> st_q == ST_IDLE); // R9
endmodule

// File: rtl/amsq_strobes.sv
module amsq_strobes
  import amsq_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  bus_st_e st_i,
  input  logic    we_i,
  output logic    as_no,
  output logic    ds_no,
  output logic    dben_no,
  output logic    oe_o,
  output logic    done_o
);
  logic active, late;

  assign active = st_i inside {ST_S1, ST_S2, ST_S3, ST_SW, ST_S4};
  assign late   = st_i inside {ST_S3, ST_SW, ST_S4};

  always_comb begin
    as_no   = !active;
    ds_no   = !(we_i ? late : active);
    dben_no = !(we_i ? active : late);
    oe_o    = we_i && (late || st_i == ST_S2);
    done_o  = st_i == ST_S5;
  end

  AST_DS_INSIDE_AS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ds_no |-> !as_no); // R2
  AST_WR_DS_LAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !ds_no && $past(ds_no)) |-> $past(!as_no, 2)); // R3
  AST_OE_WRITE_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_o |-> (we_i && !as_no)); // R4
  AST_DONE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (as_no && ds_no && dben_no && !oe_o)); // R9
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R9
endmodule

// File: rtl/amsq_datapath.sv
module amsq_datapath
  import amsq_pkg::*;
#(
  parameter int AW  = 32,
  parameter int DW  = 32,
  parameter int SZW = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  bus_st_e        st_i,
  input  logic           req_i,
  input  logic           we_i,
  input  logic [AW-1:0]  addr_i,
  input  logic [SZW-1:0] size_i,
  input  logic [DW-1:0]  wdata_i,
  input  logic           sample_i,
  input  logic           ack0_ni,
  input  logic           ack1_ni,
  input  logic [DW-1:0]  data_i,
  output logic           we_o,
  output logic [AW-1:0]  addr_o,
  output logic [SZW-1:0] size_o,
  output logic [DW-1:0]  wdata_o,
  output logic [DW-1:0]  rdata_o,
  output logic [1:0]     port_o
);
  logic start, capture;
  assign start   = (st_i == ST_IDLE) && req_i;
  assign capture = (st_i == ST_S4) && !we_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_o    <= 1'b0;
      addr_o  <= '0;
      size_o  <= '0;
      wdata_o <= '0;
    end else if (start) begin
      we_o    <= we_i;
      addr_o  <= addr_i;
      size_o  <= size_i;
      wdata_o <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) port_o <= PW_8;
    else if (sample_i) port_o <= port_of(ack0_ni, ack1_ni);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else if (capture) rdata_o <= data_i;
  end

  AST_ADDR_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i != ST_IDLE) |=> ($stable(addr_o) && $stable(we_o) && $stable(size_o))); // R10
  AST_RDATA_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_S5) |=> $stable(rdata_o)); // R8
endmodule

// File: rtl/async_bus_master.sv
module async_bus_master
  import amsq_pkg::*;
#(
  parameter int AW  = 32,
  parameter int DW  = 32,
  localparam int SZW = $clog2(DW / 8)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           req_i,
  input  logic           we_i,
  input  logic [AW-1:0]  addr_i,
  input  logic [SZW-1:0] size_i,
  input  logic [DW-1:0]  wdata_i,
  output logic           done_o,
  output logic [DW-1:0]  rdata_o,
  output logic [1:0]     port_o,
  output logic [AW-1:0]  addr_o,
  output logic [SZW-1:0] size_o,
  output logic           bus_wr_o,
  output logic           as_no,
  output logic           ds_no,
  output logic           dben_no,
  output logic [DW-1:0]  data_o,
  output logic           data_oe_o,
  input  logic [DW-1:0]  data_i,
  input  logic           ack0_ni,
  input  logic           ack1_ni
);
  bus_st_e st;
  logic    ack_seen, sample;

  assign ack_seen = !(ack0_ni && ack1_ni);
  assign sample   = (st == ST_S3) && ack_seen;

  amsq_fsm u_fsm (
    .clk_i, .rst_ni, .req_i,
    .ack_seen_i (ack_seen),
    .st_o       (st)
  );

  amsq_strobes u_strobes (
    .clk_i, .rst_ni,
    .st_i    (st),
    .we_i    (bus_wr_o),
    .as_no, .ds_no, .dben_no,
    .oe_o    (data_oe_o),
    .done_o
  );

  amsq_datapath #(.AW(AW), .DW(DW), .SZW(SZW)) u_dp (
    .clk_i, .rst_ni,
    .st_i     (st),
    .req_i, .we_i, .addr_i, .size_i, .wdata_i,
    .sample_i (sample),
    .ack0_ni, .ack1_ni, .data_i,
    .we_o     (bus_wr_o),
    .addr_o, .size_o,
    .wdata_o  (data_o),
    .rdata_o, .port_o
  );
endmodule

// File: tb/async_bus_master_test.sv
`timescale 1ns/1ps
module async_bus_master_test;
  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [31:0] addr_i = '0, wdata_i = '0, data_i = '0;
  logic [1:0]  size_i = '0;
  logic        ack0_ni = 1'b1, ack1_ni = 1'b1;
  logic        done_o, bus_wr_o, as_no, ds_no, dben_no, data_oe_o;
  logic [31:0] rdata_o, addr_o, data_o;
  logic [1:0]  port_o, size_o;

  int n_run = 0, n_fail = 0;
  bit checking = 1'b0, finished = 1'b0;

  always #2 clk_i = ~clk_i;

  async_bus_master uut (.*);

  // behavioural model: tick count t since accept, sampled tick ts
  int t = 0, ts = 0;
  bit m_we; logic [31:0] m_addr, m_wdata, m_rdata = '0; logic [1:0] m_size, m_port;

  always @(posedge clk_i) begin
    if (!rst_ni) begin t = 0; ts = 0; m_rdata = '0; end
    else if (t == 0) begin
      if (req_i) begin
        t = 1; ts = 0; m_we = we_i; m_addr = addr_i; m_wdata = wdata_i; m_size = size_i;
      end
    end else if (ts != 0 && t == ts + 2) begin
      t = 0; ts = 0;
    end else begin
      if (ts == 0 && t >= 3 && (t % 2) == 1 && !(ack0_ni && ack1_ni)) begin
        ts = t;
        m_port = (!ack0_ni && !ack1_ni) ? 2'b10 : (!ack1_ni ? 2'b01 : 2'b00);
      end
      if (ts != 0 && t == ts + 1 && !m_we) m_rdata = data_i;
      t++;
    end
  end

  function automatic void chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s t=%0d actual=%h expected=%h", req, what, t, act, exp);
    end
  endfunction

  always @(negedge clk_i) begin
    if (checking && rst_ni) begin
      bit act, e_as, e_ds, e_db, e_oe, e_done;
      string rq;
      act    = (t >= 1) && (ts == 0 || t <= ts + 1);
      e_as   = act;
      e_ds   = act && (m_we ? t >= 3 : 1'b1);
      e_db   = act && (m_we ? 1'b1 : t >= 3);
      e_oe   = act && m_we && t >= 2;
      e_done = (ts != 0) && (t == ts + 2);
      rq = (ts == 0 && t >= 4) ? "R6" : "R2";
      chk(as_no == !e_as, rq, "as_no", 32'(as_no), 32'(!e_as));
      chk(ds_no == !e_ds, m_we ? "R3" : rq, "ds_no", 32'(ds_no), 32'(!e_ds));
      chk(dben_no == !e_db, "R5", "dben_no", 32'(dben_no), 32'(!e_db));
      chk(data_oe_o == e_oe, "R4", "data_oe_o", 32'(data_oe_o), 32'(e_oe));
      chk(done_o == e_done, "R9", "done_o", 32'(done_o), 32'(e_done));
      if (e_oe) chk(data_o == m_wdata, "R4", "data_o", data_o, m_wdata);
      if (act) begin
        chk(addr_o == m_addr, "R10", "addr_o", addr_o, m_addr);
        chk({bus_wr_o, size_o} == {m_we, m_size}, "R10", "wr/size", 32'({bus_wr_o, size_o}), 32'({m_we, m_size}));
      end
      if (e_done) begin
        chk(port_o == m_port, "R7", "port_o", 32'(port_o), 32'(m_port));
        if (!m_we) chk(rdata_o == m_rdata, "R8", "rdata_o", rdata_o, m_rdata);
      end
    end
  end

  // one cycle: waits = empty sampling ticks, pat = {ack1_n, ack0_n} at the answering tick
  task automatic run_cycle(bit we, logic [31:0] a, logic [1:0] sz, logic [31:0] wd,
                           int waits, logic [1:0] pat, bit glitch, bit hold_req);
    int cnt = 0;
    @(negedge clk_i);
    req_i = 1; we_i = we; addr_i = a; size_i = sz; wdata_i = wd;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk_i);
      if (t == 0) break;
      if (hold_req && ts == 0) begin
        we_i = !we; addr_i = ~a; size_i = ~sz;
      end else req_i = 0;
      data_i = 32'hC0DE_0000 + 32'(t);
      {ack1_ni, ack0_ni} = 2'b11;
      if (ts == 0 && t >= 3 && (t % 2) == 1) begin
        if (cnt == waits) {ack1_ni, ack0_ni} = pat;
        else cnt++;
      end else if (glitch && ts == 0 && t >= 4) {ack1_ni, ack0_ni} = 2'b00;
    end
    req_i = 0; {ack1_ni, ack0_ni} = 2'b11;
  endtask

  initial begin
    #1;
    repeat (3) @(negedge clk_i);
    chk(as_no && ds_no && dben_no && !data_oe_o && !done_o, "R1", "reset idle",
        {27'd0, as_no, ds_no, dben_no, data_oe_o, done_o}, 32'b11100);
    rst_ni = 1;
    @(negedge clk_i);
    checking = 1;
    chk(as_no && !done_o, "R1", "idle after reset", 32'(as_no), 32'd1);

    run_cycle(0, 32'h1000_0004, 2'b00, '0, 0, 2'b00, 0, 0);            // R2 R7 R8: 32-bit read
    run_cycle(0, 32'h2000_0008, 2'b10, '0, 2, 2'b01, 0, 0);            // R6: 16-bit, two waits
    run_cycle(0, 32'h3000_000C, 2'b01, '0, 1, 2'b10, 1, 0);            // R6: stray acks ignored
    run_cycle(1, 32'h4000_0010, 2'b00, 32'hDEAD_BEEF, 0, 2'b00, 0, 0); // R3 R4 R5
    run_cycle(1, 32'h5000_0014, 2'b01, 32'h1234_5678, 3, 2'b10, 1, 0); // R4: 1 byte, all lines
    run_cycle(1, 32'h6000_0018, 2'b11, 32'hA5A5_5A5A, 1, 2'b01, 0, 1); // R10 write
    run_cycle(0, 32'h7000_001C, 2'b10, '0, 0, 2'b01, 0, 1);            // R10 read

    // reset in the middle of a cycle: R1
    @(negedge clk_i);
    req_i = 1; we_i = 1; addr_i = 32'h8000_0000;
    @(negedge clk_i); req_i = 0;
    repeat (3) @(negedge clk_i);
    checking = 0; rst_ni = 0;
    @(negedge clk_i);
    chk(as_no && ds_no && dben_no && !data_oe_o && !done_o, "R1", "mid-cycle reset",
        {27'd0, as_no, ds_no, dben_no, data_oe_o, done_o}, 32'b11100);
    rst_ni = 1;
    @(negedge clk_i);
    checking = 1;
    run_cycle(0, 32'h9000_0020, 2'b00, '0, 0, 2'b00, 0, 0);            // R8 after reset
    repeat (2) @(negedge clk_i);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule